// File: doc/BRIEF.md
# Burst Address Generator

This block produces the access address for a synchronous memory array. On each clock edge where the active-low clock enable is asserted, it does one of three things. It loads a fresh external address, or it steps an internal two-bit burst counter, or it ends the current burst when the select-valid input is low. While the clock enable is high, the block holds its state.

A static strap chooses the burst order. In interleaved order, the low address bits are the loaded low bits XOR the burst count. In linear order, they are the loaded low bits plus the count, wrapped modulo four. The upper address bits keep their loaded value for the whole burst. After the fourth access the sequence wraps back to its first address.

An advance request with no burst in progress means the controller broke protocol, because a deselect must be followed by a load. The block raises an error flag for such a request and keeps the address unchanged.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `acc_addr` is 0, `proto_err` is 0, and no burst is in progress.
- R2: On an edge where `clk_en_n` is 1, `acc_addr` and `proto_err` keep their values, whatever the other inputs are.
- R3: On an enabled edge with `sel_valid`=1 and `adv_ld`=0, `acc_addr` takes the value of `ext_addr` one cycle later. `proto_err` becomes 0 and the burst count restarts at 0.
- R4: With `order_il`=1, the k-th advance after a load sets the low `BURST_W` bits to (loaded low bits XOR (k mod 4)).
- R5: With `order_il`=0, the k-th advance after a load sets the low `BURST_W` bits to ((loaded low bits + k) mod 4).
- R6: During advances, the address bits above the low `BURST_W` bits stay at their loaded value.
- R7: The fourth advance after a load returns `acc_addr` to the loaded address.
- R8: On an enabled edge with `sel_valid`=0, `acc_addr` holds, the burst ends and `proto_err` becomes 0. This takes priority over `adv_ld`.
- R9: An enabled advance (`sel_valid`=1, `adv_ld`=1) with no burst in progress sets `proto_err` to 1 and leaves `acc_addr` unchanged. A valid advance clears `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock qualifier; when high, all state holds |
| adv_ld | input | 1 | 1 = advance the burst, 0 = load `ext_addr` |
| sel_valid | input | 1 | 1 = device selected; 0 = deselect, which ends the burst |
| order_il | input | 1 | Burst order strap: 1 = interleaved, 0 = linear |
| ext_addr | input | ADDR_W | External address to load |
| acc_addr | output | ADDR_W | Current access address |
| proto_err | output | 1 | Set by an advance with no burst in progress |

## Verification
The bench builds the block with `ADDR_W`=12 and the default `BURST_W`=2. The narrow address keeps the random upper bits easy to read, while the two-bit burst field keeps the real four-beat sequence. With this setting, every start offset from 0 to 3 is reachable in both burst orders. Each burst runs five advances so that the wrap is observed, and random clock-enable stalls fall between the beats. The sequence also covers a deselect, advances that come after it, and the reload that recovers from the error.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_DESEL = 2'd1,
        OP_LOAD  = 2'd2,
        OP_ADV   = 2'd3
    } bag_op_e;
endpackage

// File: rtl/bag_ctrl.sv
module bag_ctrl
    import bag_pkg::*;
(
    input  logic    clk_en_n,
    input  logic    sel_valid,
    input  logic    adv_ld,
    output bag_op_e op
);
    always_comb begin
        if (clk_en_n)        op = OP_HOLD;
        else if (!sel_valid) op = OP_DESEL;
        else if (!adv_ld)    op = OP_LOAD;
        else                 op = OP_ADV;
    end
endmodule

// File: rtl/bag_order.sv
module bag_order #(
    parameter int BW = 2
) (
    input  logic [BW-1:0] start,
    input  logic [BW-1:0] cnt,
    input  logic          il,
    output logic [BW-1:0] lo
);
    logic [BW-1:0] xr;
    logic [BW-1:0] sm;

    for (genvar i = 0; i < BW; i++) begin : g_xor
        assign xr[i] = start[i] ^ cnt[i];
    end

    assign sm = BW'(start + cnt);
    assign lo = il ? xr : sm;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              adv_ld,
    input  logic              sel_valid,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              proto_err
);
    localparam int UP_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [BURST_W-1:0] start;
        logic [BURST_W-1:0] cnt;
        logic               active;
        logic               err;
    } st_t;

    st_t st_d, st_q;
    bag_op_e op;
    logic [BURST_W-1:0] cnt_nx;
    logic [BURST_W-1:0] lo_nx;

    bag_ctrl u_ctrl (
        .clk_en_n (clk_en_n),
        .sel_valid(sel_valid),
        .adv_ld   (adv_ld),
        .op       (op)
    );

    assign cnt_nx = BURST_W'(st_q.cnt + 1'b1);

    bag_order #(.BW(BURST_W)) u_order (
        .start(st_q.start),
        .cnt  (cnt_nx),
        .il   (order_il),
        .lo   (lo_nx)
    );

    always_comb begin
        st_d = st_q;
        case (op)
            OP_DESEL: begin
                st_d.active = 1'b0;
                st_d.err    = 1'b0;
            end
            OP_LOAD: begin
                st_d.addr   = ext_addr;
                st_d.start  = ext_addr[BURST_W-1:0];
                st_d.cnt    = '0;
                st_d.active = 1'b1;
                st_d.err    = 1'b0;
            end
            OP_ADV: begin
                if (st_q.active) begin
                    st_d.cnt  = cnt_nx;
                    st_d.addr = {st_q.addr[ADDR_W-1:BURST_W], lo_nx};
                    st_d.err  = 1'b0;
                end else begin
                    st_d.err  = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_addr  = st_q.addr;
    assign proto_err = st_q.err;

    if (UP_W < 1) begin : g_bad_param
        initial $error("ADDR_W must exceed BURST_W");
    end
endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
    parameter int AW = 18,
    parameter int BW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en_n,
    input logic          adv_ld,
    input logic          sel_valid,
    input logic [AW-1:0] ext_addr,
    input logic [AW-1:0] acc_addr,
    input logic          proto_err
);
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(acc_addr) && $stable(proto_err))); // R2

    AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && sel_valid && !adv_ld) |=> (acc_addr == $past(ext_addr) && !proto_err)); // R3

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && sel_valid && adv_ld) |=> (acc_addr[AW-1:BW] == $past(acc_addr[AW-1:BW]))); // R6

    AST_DESEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !sel_valid) |=> ($stable(acc_addr) && !proto_err)); // R8

    AST_ERR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && sel_valid && adv_ld && proto_err) |=> (proto_err && $stable(acc_addr))); // R9
endmodule

bind burst_addr_gen bag_checker #(.AW(ADDR_W), .BW(BURST_W)) u_bag_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .adv_ld   (adv_ld),
    .sel_valid(sel_valid),
    .ext_addr (ext_addr),
    .acc_addr (acc_addr),
    .proto_err(proto_err)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b1;
    logic          adv_ld = 1'b0;
    logic          sel_valid = 1'b0;
    logic          order_il = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] acc_addr;
    logic          proto_err;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_addr = 0, m_base = 0, m_k = 0;
    bit m_active = 0, m_err = 0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BURST_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
        .sel_valid(sel_valid), .order_il(order_il), .ext_addr(ext_addr),
        .acc_addr(acc_addr), .proto_err(proto_err)
    );

    function automatic int burst_addr(int base, int k, bit il);
        int lo;
        if (il) lo = (base % 4) ^ (k % 4);
        else    lo = ((base % 4) + k) % 4;
        return (base / 4) * 4 + lo;
    endfunction

    task automatic check(string tag, int exp_addr, bit exp_err);
        checks++;
        if (int'(acc_addr) != exp_addr || proto_err != exp_err) begin
            errors++;
            $display("FAIL %s: addr=%0h err=%0b expected addr=%0h err=%0b",
                     tag, acc_addr, proto_err, exp_addr, exp_err);
        end
    endtask

    // drive on falling edge, let the rising edge pass, update model, compare
    task automatic step(bit cen_n, bit sel, bit adv, int addr, string tag);
        @(negedge clk);
        clk_en_n  = cen_n;
        sel_valid = sel;
        adv_ld    = adv;
        ext_addr  = AW'(addr);
        @(posedge clk);
        #1;
        if (!cen_n) begin
            if (!sel) begin
                m_active = 0; m_err = 0;
            end else if (!adv) begin
                m_addr = addr; m_base = addr; m_k = 0; m_active = 1; m_err = 0;
            end else if (m_active) begin
                m_k++;
                m_addr = burst_addr(m_base, m_k, order_il);
                m_err = 0;
            end else begin
                m_err = 1;
            end
        end
        check(tag, m_addr, m_err);
    endtask

    task automatic maybe_stall();
        if ($urandom_range(0, 2) == 0)
            step(1'b1, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 4095), "R2 stall");
    endtask

    bit done = 0;

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // advance before any load: protocol error
        step(1'b0, 1'b1, 1'b1, 0, "R9 adv before load");
        step(1'b1, 1'b1, 1'b0, 12'h123, "R2 stall keeps err");

        for (int mode = 1; mode >= 0; mode--) begin
            order_il = mode[0];
            for (int s = 0; s < 4; s++) begin
                base = ($urandom_range(0, 1023) * 4) + s;
                step(1'b0, 1'b1, 1'b0, base, "R3 load");
                for (int k = 1; k <= 5; k++) begin
                    maybe_stall();
                    step(1'b0, 1'b1, 1'b1, $urandom_range(0, 4095),
                         mode ? "R4 interleaved advance" : "R5 linear advance");
                    checks++;
                    if (int'(acc_addr[AW-1:2]) != base / 4) begin
                        errors++;
                        $display("FAIL R6: upper=%0h expected %0h", acc_addr[AW-1:2], base / 4);
                    end
                    if (k == 4) begin
                        checks++;
                        if (int'(acc_addr) != base) begin
                            errors++;
                            $display("FAIL R7: addr=%0h expected %0h", acc_addr, base);
                        end
                    end
                end
            end
        end

        // deselect priority, then advance without reload
        order_il = 1'b0;
        step(1'b0, 1'b1, 1'b0, 12'hA51, "R3 load");
        step(1'b0, 1'b1, 1'b1, 0, "R5 linear advance");
        step(1'b0, 1'b0, 1'b0, 12'h777, "R8 deselect ignores load");
        step(1'b0, 1'b0, 1'b1, 12'h777, "R8 deselect holds");
        step(1'b0, 1'b1, 1'b1, 0, "R9 adv after deselect");
        step(1'b0, 1'b1, 1'b1, 0, "R9 err persists");
        step(1'b1, 1'b1, 1'b0, 12'h001, "R2 stall holds err");
        step(1'b0, 1'b0, 1'b1, 0, "R8 deselect clears err");
        step(1'b0, 1'b1, 1'b1, 0, "R9 adv after deselect again");
        step(1'b0, 1'b1, 1'b0, 12'h3F2, "R3 reload clears err");
        step(1'b0, 1'b1, 1'b1, 0, "R5 linear advance after reload");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule